// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small, fully associative store of recent virtual-to-physical translations for a 48-bit virtual address space. A lookup presents a virtual address and the current address-space number. In the same cycle the block answers with a hit flag, the physical address and the permission bits of the matching translation. Every entry carries a 12-bit address-space tag. Translations that belong to other address spaces therefore stay resident across a context switch and only answer when their own tag is current.

An entry maps either a 4 KB page or a 2 MB page. The page walker installs its results through a one-cycle fill port. When a fill overlaps translations that are already held, it replaces them, so that no address ever matches two entries. Three maintenance inputs remove translations: one drops the page that covers a given address in one address space, one drops every entry of one address space, and one empties the whole store. All three take effect at the next clock edge. When the store is full, slots are reused in round-robin order.

Top module: `tag_xlat_cache`

## Requirements
- R1: A lookup of an address covered by a resident translation of the current address space raises `lk_hit` in the same cycle, with no clock edge between the inputs and the answer.
- R2: A hit requires the entry's 12-bit address-space tag to equal `lk_ctx`. The same virtual page may be held for several address spaces at once, and each lookup returns its own mapping.
- R3: For a 4 KB entry, `lk_pa` is the stored 28-bit frame number followed by virtual bits 11..0 unchanged.
- R4: For a 2 MB entry, `lk_pa` is frame bits 27..9 followed by virtual bits 20..0 unchanged. Every address in the 2 MB range hits. The first address past the range misses.
- R5: `lk_flags` returns the six attribute bits stored at fill time: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 no-execute, bit 4 accessed, bit 5 dirty.
- R6: A page invalidation (`inv_en`, `inv_vpn`, `inv_ctx`) removes the entry of that address space whose page covers the address, including a 2 MB entry. Other entries stay resident.
- R7: An address-space flush (`fctx_en`, `fctx_id`) removes every entry with that tag and keeps entries with other tags.
- R8: `flush_all` removes every entry at the next clock edge.
- R9: While a slot is free, a fill takes a free slot, so no resident translation is lost until all 64 slots hold entries.
- R10: Once all 64 slots are full, fills that overlap nothing evict slots in round-robin order. Starting from an empty store filled in order, the 65th such fill evicts the first translation and the 66th evicts the second.
- R11: A fill is discarded when, in the same cycle, a page invalidation of the same address space hits the page being filled, a flush of its address space occurs, or `flush_all` is asserted. A fill is kept when the same-cycle invalidation targets a different page.
- R12: A fill replaces every resident entry of the same address space that overlaps its page. This holds both when the same 4 KB page is re-filled and when a 2 MB fill covers existing 4 KB entries, so a lookup never matches more than one entry.
- R13: On a miss, `lk_pa` and `lk_flags` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_va | input | 48 | Lookup virtual address |
| lk_ctx | input | 12 | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 40 | Translated physical address (zero on miss) |
| lk_flags | output | 6 | Attribute bits of the hit entry (zero on miss) |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 36 | Virtual page number (bits 47..12) of the fill |
| fill_ctx | input | 12 | Address-space tag of the fill |
| fill_huge | input | 1 | Fill maps a 2 MB page |
| fill_ppn | input | 28 | Physical frame number of the fill |
| fill_flags | input | 6 | Attribute bits of the fill |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 36 | Virtual page number to invalidate |
| inv_ctx | input | 12 | Address space of the invalidation |
| fctx_en | input | 1 | Flush one address space |
| fctx_id | input | 12 | Address space to flush |
| flush_all | input | 1 | Flush every entry |

## Verification
The assertions take for granted that reset is applied before the first operation. They also assume that a 2 MB fill carries a frame number and a page number whose low nine bits are zero, since those bits are not used for such an entry. The bench issues every fill, invalidation and flush as a one-cycle pulse on a settled clock phase, and it aligns each 2 MB fill as required. It drives all lookups combinationally between edges, so the single-match and flush properties are only checked against legal traffic.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PAGE_SHIFT = 12;  // 4 KB page offset width
  localparam int HUGE_SPAN  = 9;   // extra offset bits of a 2 MB page
  localparam int FLAG_W     = 6;   // present, wr, user, nx, accessed, dirty
  typedef logic [FLAG_W-1:0] xlat_flags_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 64,
  parameter int VPN_W = 36,
  parameter int CTX_W = 12
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [CTX_W-1:0] ent_ctx [N],
  input  logic [VPN_W-1:0] ent_vpn [N],
  input  logic [N-1:0]     ent_huge,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  input  logic             q_huge,
  output logic [N-1:0]     hits
);
  import xlat_pkg::*;

  // An entry overlaps the query page when the tags agree, the 2 MB frame
  // agrees, and the low page bits agree unless either side is a 2 MB page.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic hi_eq, lo_eq;
    assign hi_eq   = ent_vpn[i][VPN_W-1:HUGE_SPAN] == q_vpn[VPN_W-1:HUGE_SPAN];
    assign lo_eq   = ent_vpn[i][HUGE_SPAN-1:0] == q_vpn[HUGE_SPAN-1:0];
    assign hits[i] = ent_valid[i] && (ent_ctx[i] == q_ctx) && hi_eq &&
                     (ent_huge[i] || q_huge || lo_eq);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             full
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;

  assign full = &valid;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (advance) rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (advance) rr_q <= rr_d;
  end

  assign idx = full ? rr_q : free_idx;

  // R9: a free slot is never passed over while the pointer is in use
  always_comb begin
    if (rst_n && !full) assert (!valid[idx]) else $error("p_free_first_r9");
  end
endmodule

// File: rtl/tag_xlat_cache.sv
module tag_xlat_cache #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int CTX_W   = 12,
  localparam int VPN_W  = VA_W - xlat_pkg::PAGE_SHIFT,
  localparam int PPN_W  = PA_W - xlat_pkg::PAGE_SHIFT,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [CTX_W-1:0]   lk_ctx,
  output logic               lk_hit,
  output logic [PA_W-1:0]    lk_pa,
  output logic [5:0]         lk_flags,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [CTX_W-1:0]   fill_ctx,
  input  logic               fill_huge,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [5:0]         fill_flags,
  input  logic               inv_en,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic [CTX_W-1:0]   inv_ctx,
  input  logic               fctx_en,
  input  logic [CTX_W-1:0]   fctx_id,
  input  logic               flush_all
);
  import xlat_pkg::*;

  localparam int HUGE_OFS = PAGE_SHIFT + HUGE_SPAN;

  // Entry state: valid bits are reset, payload is not.
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ENTRIES-1:0] huge_q;
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  xlat_flags_t        flg_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_hits, inv_hits, fill_hits, ctx_clr;
  logic [IDX_W-1:0]   vic_idx, ovl_idx, wr_idx;
  logic               vic_full, fill_kill, fill_go, ovl_any, rr_adv;

  // Three comparator banks: lookup, page invalidation, fill overlap.
  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_lk_cmp (
    .ent_valid(valid_q), .ent_ctx(ctx_q), .ent_vpn(vpn_q), .ent_huge(huge_q),
    .q_vpn(lk_va[VA_W-1:PAGE_SHIFT]), .q_ctx(lk_ctx), .q_huge(1'b0),
    .hits(lk_hits));

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_inv_cmp (
    .ent_valid(valid_q), .ent_ctx(ctx_q), .ent_vpn(vpn_q), .ent_huge(huge_q),
    .q_vpn(inv_vpn), .q_ctx(inv_ctx), .q_huge(1'b0), .hits(inv_hits));

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_fill_cmp (
    .ent_valid(valid_q), .ent_ctx(ctx_q), .ent_vpn(vpn_q), .ent_huge(huge_q),
    .q_vpn(fill_vpn), .q_ctx(fill_ctx), .q_huge(fill_huge), .hits(fill_hits));

  xlat_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .advance(rr_adv),
    .idx(vic_idx), .full(vic_full));

  // Lookup: and-or mux over the (at most one) hitting entry.
  always_comb begin
    lk_hit   = |lk_hits;
    lk_pa    = '0;
    lk_flags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hits[i]) begin
        lk_pa    = lk_pa | (huge_q[i] ?
                   {ppn_q[i][PPN_W-1:HUGE_SPAN], lk_va[HUGE_OFS-1:0]} :
                   {ppn_q[i], lk_va[PAGE_SHIFT-1:0]});
        lk_flags = lk_flags | flg_q[i];
      end
    end
  end

  // Fill arbitration: any same-cycle removal of the fill's page wins.
  always_comb begin
    fill_kill = flush_all || (fctx_en && (fctx_id == fill_ctx)) ||
                (inv_en && (inv_ctx == fill_ctx) &&
                 (inv_vpn[VPN_W-1:HUGE_SPAN] == fill_vpn[VPN_W-1:HUGE_SPAN]) &&
                 (fill_huge || (inv_vpn[HUGE_SPAN-1:0] == fill_vpn[HUGE_SPAN-1:0])));
    fill_go = fill_en && !fill_kill;
    ovl_any = |fill_hits;
    ovl_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_hits[i]) ovl_idx = IDX_W'(i);
    end
    wr_idx = ovl_any ? ovl_idx : vic_idx;
    rr_adv = fill_go && !ovl_any && vic_full;
  end

  // Next-state valid vector.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ctx_clr[i] = fctx_en && (ctx_q[i] == fctx_id);
    end
    valid_d = valid_q & ~ctx_clr & ~(inv_en ? inv_hits : '0);
    if (fill_go) begin
      valid_d         = valid_d & ~fill_hits;
      valid_d[wr_idx] = 1'b1;
    end
    if (flush_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      ctx_q[wr_idx]  <= fill_ctx;
      vpn_q[wr_idx]  <= fill_vpn;
      huge_q[wr_idx] <= fill_huge;
      ppn_q[wr_idx]  <= fill_ppn;
      flg_q[wr_idx]  <= fill_flags;
    end
  end

  // R12: overlap replacement keeps lookups single-match
  p_single_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));

  // R8: global flush empties the store
  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  // R11: an accepted fill is resident in the slot chosen for it
  p_fill_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> valid_q[$past(wr_idx)]);

  // R9: a fill into a non-full store adds one entry and evicts nothing
  p_no_evict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !ovl_any && !vic_full && !inv_en && !fctx_en) |=>
    ($countones(valid_q) == $countones($past(valid_q)) + 1));

  // R6: an invalidated entry is gone unless a fill rewrote it
  p_inv_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !fill_go) |=> ((valid_q & $past(inv_hits)) == '0));
endmodule

// File: tb/tag_xlat_cache_test.sv
`timescale 1ns/1ps
module tag_xlat_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] lk_va;
  logic [11:0] lk_ctx;
  logic        lk_hit;
  logic [39:0] lk_pa;
  logic [5:0]  lk_flags;
  logic        fill_en;
  logic [35:0] fill_vpn;
  logic [11:0] fill_ctx;
  logic        fill_huge;
  logic [27:0] fill_ppn;
  logic [5:0]  fill_flags;
  logic        inv_en;
  logic [35:0] inv_vpn;
  logic [11:0] inv_ctx;
  logic        fctx_en;
  logic [11:0] fctx_id;
  logic        flush_all;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tag_xlat_cache uut (.*);

  function automatic logic [39:0] pa4k(input logic [27:0] ppn, input logic [47:0] va);
    return {ppn, va[11:0]};
  endfunction

  function automatic logic [39:0] pa2m(input logic [27:0] ppn, input logic [47:0] va);
    return {ppn[27:9], va[20:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Combinational lookup, sampled between edges.
  task automatic look(input logic [47:0] va, input logic [11:0] ctx, input bit hit,
                      input logic [39:0] pa, input logic [5:0] flg, input string req);
    @(negedge clk);
    lk_va = va; lk_ctx = ctx;
    #1;
    chk(lk_hit == hit, {req, " hit"}, 64'(lk_hit), 64'(hit));
    chk(lk_pa == (hit ? pa : 40'h0), {req, " pa"}, 64'(lk_pa), 64'(hit ? pa : 40'h0));
    chk(lk_flags == (hit ? flg : 6'h0), {req, " flags"}, 64'(lk_flags),
        64'(hit ? flg : 6'h0));
  endtask

  task automatic pulse(input bit f, input logic [47:0] fva, input logic [11:0] fc,
                       input bit fh, input logic [27:0] fp, input logic [5:0] ff,
                       input bit iv, input logic [47:0] iva, input logic [11:0] ic,
                       input bit fx, input logic [11:0] fxid, input bit fa);
    @(negedge clk);
    fill_en = f; fill_vpn = fva[47:12]; fill_ctx = fc; fill_huge = fh;
    fill_ppn = fp; fill_flags = ff;
    inv_en = iv; inv_vpn = iva[47:12]; inv_ctx = ic;
    fctx_en = fx; fctx_id = fxid; flush_all = fa;
    @(negedge clk);
    fill_en = 0; inv_en = 0; fctx_en = 0; flush_all = 0;
  endtask

  task automatic fill(input logic [47:0] va, input logic [11:0] c, input bit h,
                      input logic [27:0] p, input logic [5:0] fl);
    pulse(1, va, c, h, p, fl, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic inv(input logic [47:0] va, input logic [11:0] c);
    pulse(0, 0, 0, 0, 0, 0, 1, va, c, 0, 0, 0);
  endtask

  task automatic flush();
    pulse(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    look(48'h0000_1234_5000, 12'h003, 0, 0, 0, "R13 reset miss");
  endtask

  task automatic t_basic();
    flush();
    fill(48'h1234_5678_9000, 12'h003, 0, 28'h0ABCDEF, 6'h03);
    look(48'h1234_5678_9ABC, 12'h003, 1, pa4k(28'h0ABCDEF, 48'h1234_5678_9ABC), 6'h03,
         "R1 R3 R5 4K hit");
    fill(48'h1234_5678_A000, 12'h003, 0, 28'h0000111, 6'h3C);
    look(48'h1234_5678_A000, 12'h003, 1, pa4k(28'h0000111, 48'h1234_5678_A000), 6'h3C,
         "R3 R5 second page");
    look(48'h1234_5678_B000, 12'h003, 0, 0, 0, "R13 neighbour miss");
  endtask

  task automatic t_ctx();
    look(48'h1234_5678_9ABC, 12'h004, 0, 0, 0, "R2 other ctx miss");
    fill(48'h1234_5678_9000, 12'h004, 0, 28'h0555555, 6'h01);
    look(48'h1234_5678_9ABC, 12'h004, 1, pa4k(28'h0555555, 48'h1234_5678_9ABC), 6'h01,
         "R2 ctx4 mapping");
    look(48'h1234_5678_9ABC, 12'h003, 1, pa4k(28'h0ABCDEF, 48'h1234_5678_9ABC), 6'h03,
         "R2 ctx3 kept");
  endtask

  task automatic t_huge();
    flush();
    fill(48'h0000_4060_0000, 12'h007, 1, 28'h0012200, 6'h27);
    look(48'h0000_4060_0000, 12'h007, 1, pa2m(28'h0012200, 48'h0000_4060_0000), 6'h27,
         "R4 2M base");
    look(48'h0000_407F_FFFF, 12'h007, 1, pa2m(28'h0012200, 48'h0000_407F_FFFF), 6'h27,
         "R4 2M top");
    look(48'h0000_4080_0000, 12'h007, 0, 0, 0, "R4 past range");
  endtask

  task automatic t_inv();
    flush();
    fill(48'h0000_0010_0000, 12'h002, 0, 28'h0000AAA, 6'h01);
    fill(48'h0000_0010_1000, 12'h002, 0, 28'h0000BBB, 6'h01);
    inv(48'h0000_0010_0FFF, 12'h002);
    look(48'h0000_0010_0000, 12'h002, 0, 0, 0, "R6 page dropped");
    look(48'h0000_0010_1004, 12'h002, 1, pa4k(28'h0000BBB, 48'h0000_0010_1004), 6'h01,
         "R6 neighbour kept");
    inv(48'h0000_0010_1000, 12'h009);
    look(48'h0000_0010_1000, 12'h002, 1, pa4k(28'h0000BBB, 48'h0000_0010_1000), 6'h01,
         "R6 wrong ctx no effect");
    fill(48'h0000_0060_0000, 12'h002, 1, 28'h0000400, 6'h05);
    inv(48'h0000_0065_3000, 12'h002);
    look(48'h0000_0060_0010, 12'h002, 0, 0, 0, "R6 2M dropped by inner page");
  endtask

  task automatic t_fctx();
    flush();
    fill(48'h0000_0020_0000, 12'h008, 0, 28'h0000123, 6'h01);
    fill(48'h0000_0030_0000, 12'h008, 0, 28'h0000124, 6'h01);
    fill(48'h0000_0020_0000, 12'h009, 0, 28'h0000125, 6'h01);
    pulse(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 12'h008, 0);
    look(48'h0000_0020_0000, 12'h008, 0, 0, 0, "R7 ctx8 first gone");
    look(48'h0000_0030_0000, 12'h008, 0, 0, 0, "R7 ctx8 second gone");
    look(48'h0000_0020_0000, 12'h009, 1, pa4k(28'h0000125, 48'h0000_0020_0000), 6'h01,
         "R7 ctx9 kept");
  endtask

  task automatic t_flush();
    fill(48'h0000_0070_0000, 12'h001, 0, 28'h0000777, 6'h01);
    flush();
    look(48'h0000_0070_0000, 12'h001, 0, 0, 0, "R8 flush all");
    look(48'h0000_0020_0000, 12'h009, 0, 0, 0, "R8 flush all other ctx");
  endtask

  task automatic t_race();
    flush();
    pulse(1, 48'h0000_0080_0000, 12'h00A, 0, 28'h0000888, 6'h01,
          1, 48'h0000_0080_0000, 12'h00A, 0, 0, 0);
    look(48'h0000_0080_0000, 12'h00A, 0, 0, 0, "R11 inv beats fill");
    pulse(1, 48'h0000_0080_0000, 12'h00A, 0, 28'h0000888, 6'h01,
          0, 0, 0, 1, 12'h00A, 0);
    look(48'h0000_0080_0000, 12'h00A, 0, 0, 0, "R11 ctx flush beats fill");
    pulse(1, 48'h0000_0080_0000, 12'h00A, 0, 28'h0000888, 6'h01,
          0, 0, 0, 0, 0, 1);
    look(48'h0000_0080_0000, 12'h00A, 0, 0, 0, "R11 flush all beats fill");
    pulse(1, 48'h0000_0080_0000, 12'h00A, 0, 28'h0000888, 6'h01,
          1, 48'h0000_0081_0000, 12'h00A, 0, 0, 0);
    look(48'h0000_0080_0000, 12'h00A, 1, pa4k(28'h0000888, 48'h0000_0080_0000), 6'h01,
         "R11 other page fill kept");
  endtask

  task automatic t_overlap();
    flush();
    fill(48'h0000_4060_1000, 12'h001, 0, 28'h0000AAA, 6'h01);
    fill(48'h0000_4060_1000, 12'h001, 0, 28'h0000BBB, 6'h03);
    look(48'h0000_4060_1234, 12'h001, 1, pa4k(28'h0000BBB, 48'h0000_4060_1234), 6'h03,
         "R12 refill replaces");
    fill(48'h0000_4060_5000, 12'h001, 0, 28'h0000CCC, 6'h01);
    fill(48'h0000_4060_0000, 12'h001, 1, 28'h0003000, 6'h21);
    look(48'h0000_4060_1234, 12'h001, 1, pa2m(28'h0003000, 48'h0000_4060_1234), 6'h21,
         "R12 2M covers first");
    look(48'h0000_4060_5008, 12'h001, 1, pa2m(28'h0003000, 48'h0000_4060_5008), 6'h21,
         "R12 2M covers second");
  endtask

  task automatic t_rr();
    bit all_ok = 1;
    flush();
    for (int i = 0; i < 64; i++) begin
      fill(48'(i) << 12, 12'h005, 0, 28'(i + 100), 6'h01);
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      lk_va = 48'(i) << 12; lk_ctx = 12'h005;
      #1;
      if (!lk_hit || lk_pa != {28'(i + 100), 12'h000}) all_ok = 0;
    end
    chk(all_ok, "R9 all 64 resident", 64'(all_ok), 64'd1);
    fill(48'd64 << 12, 12'h005, 0, 28'd164, 6'h01);
    look(48'h0, 12'h005, 0, 0, 0, "R10 65th evicts first");
    look(48'h1000, 12'h005, 1, pa4k(28'd101, 48'h1000), 6'h01, "R10 second kept");
    look(48'd64 << 12, 12'h005, 1, pa4k(28'd164, 48'd64 << 12), 6'h01, "R10 new hit");
    fill(48'd65 << 12, 12'h005, 0, 28'd165, 6'h01);
    look(48'h1000, 12'h005, 0, 0, 0, "R10 66th evicts second");
    look(48'h2000, 12'h005, 1, pa4k(28'd102, 48'h2000), 6'h01, "R10 third kept");
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; lk_va = 0; lk_ctx = 0;
    fill_en = 0; fill_vpn = 0; fill_ctx = 0; fill_huge = 0; fill_ppn = 0;
    fill_flags = 0; inv_en = 0; inv_vpn = 0; inv_ctx = 0;
    fctx_en = 0; fctx_id = 0; flush_all = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_ctx();
    t_huge();
    t_inv();
    t_fctx();
    t_flush();
    t_race();
    t_overlap();
    t_rr();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule